// File: doc/BRIEF.md
# Mask-Compare Slave Selector

This block sits in front of an interconnect's arbiter and turns one requester's address into a vector of slave-select flags. Every slave window is defined at elaboration time by a base word and a mask word held in two packed parameters; an address selects a slave when it agrees with that slave's base on every bit where the mask is one. The vector has one bit per slave plus one extra top bit that marks an address no window claims, so that a later stage can route such a request to an internal error responder.

The address and an opaque payload travel alongside the select vector. A parameter chooses between a purely combinational path and a single pipeline register with a valid/ready handshake, used to cut a long timing path ahead of arbitration. A second parameter forces the address, payload and select outputs to zero whenever no request is being presented. Overlapping windows are not rejected: each window that claims the address raises its own bit.

Top module: `addr_route_decode`

## Requirements
- R1: Select bit m (0 ≤ m < NS) is 1 for a presented request exactly when ((address XOR base m) AND mask m) is zero, where base m and mask m are the AW-bit fields at bit offset m*AW of the base and mask parameters.
- R2: Select bit NS (the most significant bit) is 1 exactly when a request is presented and no slave window matches; it is never 1 together with any slave bit.
- R3: When no request is presented, every select bit is 0.
- R4: When several windows claim an address, every one of their select bits is 1.
- R5: In registered mode, a transfer accepted at a clock edge (input valid and ready both 1) appears on the outputs after that edge with output valid 1 and its own select vector, address and payload.
- R6: In registered mode, while output valid is 1 and output ready is 0, input ready is 0 and the select vector, address and payload hold their values.
- R7: In registered mode, when the held output is consumed and no new transfer is accepted at the same edge, output valid is 0 after that edge.
- R8: With zeroing enabled, select vector, address and payload outputs are all 0 whenever output valid is 0.
- R9: In combinational mode, output valid, select vector, address and payload follow the inputs in the same cycle and input ready equals output ready.
- R10: While reset is asserted, output valid, input ready (registered mode) and the select vector are 0; reset takes effect at once, and input ready returns to 1 within three clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request presented |
| in_ready | output | 1 | Request accepted when 1 with in_valid |
| in_addr | input | AW | Request address |
| in_payload | input | PW | Data carried with the request |
| out_valid | output | 1 | Decoded request presented |
| out_ready | input | 1 | Downstream takes the decoded request |
| out_hit | output | NS+1 | Slave select bits; top bit means no slave matched |
| out_addr | output | AW | Address aligned with out_hit |
| out_payload | output | PW | Payload aligned with out_hit |

## Verification
The checks assume the requester holds nothing stable on its own: address and payload may change freely, and the properties rely only on the handshake seen at the ports, with the requester keeping in_valid low while reset is asserted. The properties also assume every presented request yields at least one select bit, which holds for any window layout because the no-match bit covers the rest. Stimulus keeps in_valid low through reset, drives inputs just after each clock edge, and walks addresses at window edges, in the unmapped hole, and through a second layout where two windows overlap.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

  // Selects whether the decoded result is presented combinationally or
  // through one handshake-controlled register.
  typedef enum logic {
    STG_COMB = 1'b0,
    STG_REG  = 1'b1
  } stage_e;

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/addr_slot_match.sv
module addr_slot_match #(
  parameter int          AW   = 16,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] MASK = '0
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [AW-1:0] diff;

  // Only bits covered by the mask take part in the compare.
  always_comb begin
    diff = (addr ^ BASE) & MASK;
    hit  = valid && (diff == '0);
  end

endmodule

// File: rtl/addr_dec_core.sv
module addr_dec_core #(
  parameter int              NS       = 4,
  parameter int              AW       = 16,
  parameter logic [NS*AW-1:0] SLV_BASE = '0,
  parameter logic [NS*AW-1:0] SLV_MASK = '0
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  output logic [NS:0]   req
);

  logic [NS-1:0] slot_hit;
  logic          no_slot;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    addr_slot_match #(
      .AW   (AW),
      .BASE (SLV_BASE[g*AW +: AW]),
      .MASK (SLV_MASK[g*AW +: AW])
    ) u_match (
      .valid (valid),
      .addr  (addr),
      .hit   (slot_hit[g])
    );
  end

  // Starts from the request itself and is cleared by any claiming window.
  always_comb begin
    no_slot = valid;
    if (|slot_hit) no_slot = 1'b0;
    req = {no_slot, slot_hit};
  end

endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage
  import addr_route_pkg::*;
#(
  parameter int     NS        = 4,
  parameter int     AW        = 16,
  parameter int     PW        = 8,
  parameter stage_e STAGE     = STG_REG,
  parameter bit     ZERO_IDLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [NS:0]   in_hit,
  input  logic [AW-1:0] in_addr,
  input  logic [PW-1:0] in_payload,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [NS:0]   out_hit,
  output logic [AW-1:0] out_addr,
  output logic [PW-1:0] out_payload
);

  localparam int HW = NS + 1;
  localparam bit USE_REG = (STAGE == STG_REG);

  logic          q_valid;
  logic          q_valid_nx;
  logic [HW-1:0] q_hit;
  logic [AW-1:0] q_addr;
  logic [PW-1:0] q_payload;
  logic          reg_ready;
  logic          load_en;

  logic          sel_valid;
  logic [HW-1:0] sel_hit;
  logic [AW-1:0] sel_addr;
  logic [PW-1:0] sel_payload;

  // Next-state logic for the holding register.
  always_comb begin
    reg_ready  = rst_n && (!q_valid || out_ready);
    load_en    = USE_REG && in_valid && reg_ready;
    q_valid_nx = q_valid;
    if (load_en)        q_valid_nx = 1'b1;
    else if (out_ready) q_valid_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_hit     <= '0;
      q_addr    <= '0;
      q_payload <= '0;
    end else begin
      q_valid <= q_valid_nx;
      if (load_en) begin
        q_hit     <= in_hit;
        q_addr    <= in_addr;
        q_payload <= in_payload;
      end
    end
  end

  always_comb begin
    if (USE_REG) begin
      in_ready    = reg_ready;
      sel_valid   = q_valid;
      sel_hit     = q_hit;
      sel_addr    = q_addr;
      sel_payload = q_payload;
    end else begin
      in_ready    = out_ready;
      sel_valid   = in_valid;
      sel_hit     = in_hit;
      sel_addr    = in_addr;
      sel_payload = in_payload;
    end
  end

  if (ZERO_IDLE) begin : g_zero
    always_comb begin
      out_valid   = sel_valid;
      out_hit     = sel_valid ? sel_hit     : '0;
      out_addr    = sel_valid ? sel_addr    : '0;
      out_payload = sel_valid ? sel_payload : '0;
    end
  end else begin : g_raw
    always_comb begin
      out_valid   = sel_valid;
      out_hit     = sel_hit;
      out_addr    = sel_addr;
      out_payload = sel_payload;
    end
  end

endmodule

// File: rtl/addr_route_decode.sv
module addr_route_decode
  import addr_route_pkg::*;
#(
  parameter int               NS        = 4,
  parameter int               AW        = 16,
  parameter int               PW        = 8,
  parameter logic [NS*AW-1:0] SLV_BASE  = 64'h8000_2000_1000_0000,
  parameter logic [NS*AW-1:0] SLV_MASK  = 64'h8000_E000_F000_F000,
  parameter stage_e           STAGE     = STG_REG,
  parameter bit               ZERO_IDLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [PW-1:0] in_payload,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [NS:0]   out_hit,
  output logic [AW-1:0] out_addr,
  output logic [PW-1:0] out_payload
);

  logic        core_rst_n;
  logic [NS:0] dec_req;

  rst_sync2 u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  addr_dec_core #(
    .NS       (NS),
    .AW       (AW),
    .SLV_BASE (SLV_BASE),
    .SLV_MASK (SLV_MASK)
  ) u_core (
    .valid (in_valid),
    .addr  (in_addr),
    .req   (dec_req)
  );

  dec_out_stage #(
    .NS        (NS),
    .AW        (AW),
    .PW        (PW),
    .STAGE     (STAGE),
    .ZERO_IDLE (ZERO_IDLE)
  ) u_stage (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_hit      (dec_req),
    .in_addr     (in_addr),
    .in_payload  (in_payload),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_hit     (out_hit),
    .out_addr    (out_addr),
    .out_payload (out_payload)
  );

endmodule

// File: rtl/addr_route_decode_chk.sv
module addr_route_decode_chk
  import addr_route_pkg::*;
#(
  parameter int     NS        = 4,
  parameter int     AW        = 16,
  parameter int     PW        = 8,
  parameter stage_e STAGE     = STG_REG,
  parameter bit     ZERO_IDLE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] in_addr,
  input logic [PW-1:0] in_payload,
  input logic          out_valid,
  input logic          out_ready,
  input logic [NS:0]   out_hit,
  input logic [AW-1:0] out_addr,
  input logic [PW-1:0] out_payload
);

  // R2
  hit_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != '0));

  if (STAGE == STG_REG) begin : g_reg
    // R5
    load_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr)
                                  && out_payload == $past(in_payload)));
    // R6
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_hit)
                                     && $stable(out_addr) && $stable(out_payload)));
    // R7
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);
  end else begin : g_comb
    // R9
    pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
    // R9
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_addr == in_addr && out_payload == in_payload));
  end

  if (ZERO_IDLE) begin : g_zero
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_hit == '0 && out_addr == '0 && out_payload == '0));
  end

endmodule

bind addr_route_decode addr_route_decode_chk #(
  .NS        (NS),
  .AW        (AW),
  .PW        (PW),
  .STAGE     (STAGE),
  .ZERO_IDLE (ZERO_IDLE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_addr     (in_addr),
  .in_payload  (in_payload),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_hit     (out_hit),
  .out_addr    (out_addr),
  .out_payload (out_payload)
);

// File: tb/sim_addr_route_decode.sv
module sim_addr_route_decode;
  import addr_route_pkg::*;

  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int PW = 8;
  localparam int NV = 10;

  // {address, expected select for layout A (u0), expected select for layout B (u1)}
  // Layout A: s0 0x0xxx, s1 0x1xxx, s2 0x2000-0x3FFF, s3 0x8000-0xFFFF, hole 0x4000-0x7FFF.
  // Layout B: same s0..s2, s3 0x0000-0x7FFF (overlaps s0..s2), nothing above 0x7FFF.
  localparam logic [25:0] VEC [0:NV-1] = '{
    {16'h0123, 5'b00001, 5'b01001},
    {16'h0FFF, 5'b00001, 5'b01001},
    {16'h1FFF, 5'b00010, 5'b01010},
    {16'h2000, 5'b00100, 5'b01100},
    {16'h3ABC, 5'b00100, 5'b01100},
    {16'h4000, 5'b10000, 5'b01000},
    {16'h7FFF, 5'b10000, 5'b01000},
    {16'h8000, 5'b01000, 5'b10000},
    {16'hFFFF, 5'b01000, 5'b10000},
    {16'hC350, 5'b01000, 5'b10000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [PW-1:0] in_payload = '0;
  logic rdy0 = 1'b1;
  logic rdy1 = 1'b1;

  logic          irdy0, ovld0;
  logic [NS:0]   hit0;
  logic [AW-1:0] oaddr0;
  logic [PW-1:0] opay0;
  logic          irdy1, ovld1;
  logic [NS:0]   hit1;
  logic [AW-1:0] oaddr1;
  logic [PW-1:0] opay1;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  addr_route_decode u0 (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (irdy0), .in_addr (in_addr), .in_payload (in_payload),
    .out_valid (ovld0), .out_ready (rdy0), .out_hit (hit0), .out_addr (oaddr0), .out_payload (opay0)
  );

  addr_route_decode #(
    .SLV_BASE  (64'h0000_2000_1000_0000),
    .SLV_MASK  (64'h8000_E000_F000_F000),
    .STAGE     (STG_COMB),
    .ZERO_IDLE (1'b0)
  ) u1 (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (irdy1), .in_addr (in_addr), .in_payload (in_payload),
    .out_valid (ovld1), .out_ready (rdy1), .out_hit (hit1), .out_addr (oaddr1), .out_payload (opay1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic v, input logic [AW-1:0] a, input logic [PW-1:0] p);
    in_valid   = v;
    in_addr    = a;
    in_payload = p;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10: state during reset
    repeat (3) step();
    chk("R10 valid in reset", 32'(ovld0), 0);
    chk("R10 ready in reset", 32'(irdy0), 0);
    chk("R10 hit in reset", 32'(hit0), 0);
    chk("R8 addr in reset", 32'(oaddr0), 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R10 ready after release", 32'(irdy0), 1);

    // Table walk: R1, R2, R4, R9 on u1 combinationally; R5, R7, R8 on u0.
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [4:0] e0, e1;
      logic [PW-1:0] p;
      a  = VEC[i][25:10];
      e0 = VEC[i][9:5];
      e1 = VEC[i][4:0];
      p  = PW'(i * 7 + 3);
      drive(1'b1, a, p);
      #2;
      chk("R4 R1 comb select", 32'(hit1), 32'(e1));
      chk("R9 comb valid", 32'(ovld1), 1);
      chk("R9 comb payload", 32'(opay1), 32'(p));
      step();
      drive(1'b0, a, p);
      #2;
      chk("R5 valid after load", 32'(ovld0), 1);
      chk("R1 R2 registered select", 32'(hit0), 32'(e0));
      chk("R2 no-slave bit exclusive", 32'(hit0[NS] & (|hit0[NS-1:0])), 0);
      chk("R5 addr aligned", 32'(oaddr0), 32'(a));
      chk("R5 payload aligned", 32'(opay0), 32'(p));
      step();
      chk("R7 drained", 32'(ovld0), 0);
      chk("R8 zero hit idle", 32'(hit0), 0);
      chk("R8 zero addr idle", 32'(oaddr0), 0);
      chk("R8 zero payload idle", 32'(opay0), 0);
    end

    // R3: no request presented
    drive(1'b0, 16'h0123, 8'h55);
    #2;
    chk("R3 comb hit idle", 32'(hit1), 0);
    chk("R3 comb valid idle", 32'(ovld1), 0);
    rdy1 = 1'b0;
    #1;
    chk("R9 ready follows", 32'(irdy1), 0);
    rdy1 = 1'b1;
    #1;
    chk("R9 ready follows high", 32'(irdy1), 1);

    // R6: backpressure
    step();
    rdy0 = 1'b0;
    drive(1'b1, 16'h1234, 8'hA1);
    #2;
    chk("R6 ready when empty", 32'(irdy0), 1);
    step();
    drive(1'b1, 16'h4321, 8'hB2);
    #2;
    chk("R6 stalled ready", 32'(irdy0), 0);
    chk("R6 held addr", 32'(oaddr0), 32'h1234);
    step();
    chk("R6 still held addr", 32'(oaddr0), 32'h1234);
    chk("R6 still held hit", 32'(hit0), 32'b00010);
    chk("R6 still held payload", 32'(opay0), 32'hA1);
    rdy0 = 1'b1;
    #1;
    chk("R6 ready on consume", 32'(irdy0), 1);
    step();
    drive(1'b0, 16'h0, 8'h0);
    #2;
    chk("R5 second item addr", 32'(oaddr0), 32'h4321);
    chk("R2 second item hole", 32'(hit0), 32'b10000);
    step();
    chk("R7 drained after stall", 32'(ovld0), 0);

    // R5: back-to-back stream
    drive(1'b1, 16'h0010, 8'h01);
    step();
    drive(1'b1, 16'h1020, 8'h02);
    #2;
    chk("R5 stream 0", 32'(opay0), 32'h01);
    step();
    drive(1'b1, 16'h9030, 8'h03);
    #2;
    chk("R5 stream 1", 32'(opay0), 32'h02);
    chk("R1 stream 1 select", 32'(hit0), 32'b00010);
    step();
    drive(1'b0, 16'h0, 8'h0);
    #2;
    chk("R5 stream 2", 32'(opay0), 32'h03);
    chk("R1 stream 2 select", 32'(hit0), 32'b01000);
    step();
    chk("R7 stream drained", 32'(ovld0), 0);

    // R10: asynchronous reset while holding an item
    rdy0 = 1'b0;
    drive(1'b1, 16'h2222, 8'h77);
    step();
    drive(1'b0, 16'h0, 8'h0);
    #2;
    chk("R5 item before reset", 32'(ovld0), 1);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear valid", 32'(ovld0), 0);
    chk("R10 async clear hit", 32'(hit0), 0);
    step();
    rst_n = 1'b1;
    rdy0 = 1'b1;
    repeat (3) step();
    chk("R10 ready after second release", 32'(irdy0), 1);
    chk("R10 empty after reset", 32'(ovld0), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule